// File: doc/BRIEF.md
# Ternary-Addressed Trit Memory

This block is a synchronous random-access store for balanced-ternary words. Every trit travels as a pair of binary bits. The block holds 729 six-trit words, and a six-trit balanced-ternary address selects one of them. The three high address trits go to a row decoder and the three low trits go to a column decoder. Each decoder produces a one-of-27 select, and the cell where the selected row and column meet is the one that is read or written.

A client presents an address on every cycle. It raises the write strobe when it wants to store the write word at that address. The content of the addressed cell appears on the read bus one clock edge later. Any request that carries the unused bit pair is refused, and the error output reports the refusal in the same cycle as the read result it affects. Reset is asserted asynchronously and released on a clock edge. After reset, the whole store reads as zero trits.

Top module: `tmem_top`

## Requirements
- R1: Each trit occupies two bits. Trit i of a bus sits at bits [2i+1:2i], and trit 0 is the least significant. The code 2'b10 means -1, 2'b00 means 0, 2'b01 means +1, and 2'b11 is illegal.
- R2: Address trits 5..3 form the row value and trits 2..0 form the column value. In each, trit weights are 1, 3 and 9. The row or column index is its balanced value plus 13, which gives 0..26. All 729 addresses reach distinct cells.
- R3: When the write strobe is high and every address and data trit is legal, the write word is stored at the addressed cell on the rising clock edge.
- R4: On every rising edge, the read bus loads the content of the cell addressed before that edge. If a write to the same cell happens on the same edge, the read bus returns the content from before the write.
- R5: While reset is active, the read bus is all 2'b00 and the error output is low. After reset, every cell reads as all-zero trits until it is written.
- R6: When any address trit is 2'b11, the error output is high and the read bus is all zero after the next edge, and no cell changes.
- R7: When the write strobe is high and any write-data trit is 2'b11, the error output is high, the read bus is zero, and no cell changes. When the strobe is low, the write data is not checked.
- R8: For a legal address, exactly one row select line and exactly one column select line are active. For an address with an illegal trit in one half, that half's decoder asserts no line.
- R9: Driving reset low clears the read bus and the error output at once, without waiting for a clock edge. Release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Six-trit address; high three trits are the row, low three the column |
| wr_data | input | 12 | Six-trit word to store |
| rd_data | output | 12 | Registered six-trit content of the addressed cell |
| err | output | 1 | Registered flag for an illegal trit code in the request |

## Verification
The bench builds the block with its default parameters: three trits per address half, which gives 27 rows and 27 columns, and six data trits. With this size, every one of the 729 cells can be written and read back in a short run. A tagged sweep therefore shows that no two addresses alias. The same configuration also makes the extreme addresses (all -1 trits and all +1 trits) and the all-zero address easy to reach, along with an illegal code placed in each address half and in the data word.

// File: rtl/tmem_pkg.sv
`timescale 1ns/1ps
package tmem_pkg;

  localparam logic [1:0] TRIT_NEG  = 2'b10;
  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_POS  = 2'b01;
  localparam logic [1:0] TRIT_BAD  = 2'b11;

  // Offset digit: balanced value plus one (0, 1 or 2)
  function automatic logic [1:0] trit_digit(input logic [1:0] code);
    case (code)
      TRIT_NEG:  return 2'd0;
      TRIT_ZERO: return 2'd1;
      TRIT_POS:  return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

  function automatic int unsigned pow3(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int unsigned k = 0; k < n; k++) p = p * 3;
    return p;
  endfunction

endpackage

// File: rtl/tmem_rst_sync.sv
`timescale 1ns/1ps
module tmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/tmem_tri_decoder.sv
`timescale 1ns/1ps
module tmem_tri_decoder
  import tmem_pkg::*;
#(
  parameter int NTRITS = 3
) (
  input  logic [2*NTRITS-1:0]         trits_i,
  output logic [pow3(NTRITS)-1:0]     sel_o,
  output logic                        bad_o
);

  localparam int SIDE  = pow3(NTRITS);
  localparam int IDX_W = $clog2(SIDE);

  logic [NTRITS-1:0] bad_vec;
  logic [IDX_W-1:0]  idx;

  for (genvar i = 0; i < NTRITS; i++) begin : g_trit
    assign bad_vec[i] = (trits_i[2*i +: 2] == TRIT_BAD);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NTRITS; i++) begin
      idx = idx + IDX_W'(trit_digit(trits_i[2*i +: 2])) * IDX_W'(pow3(i));
    end
  end

  assign bad_o = |bad_vec;
  assign sel_o = bad_o ? '0 : (SIDE'(1) << idx);

endmodule

// File: rtl/tmem_store.sv
`timescale 1ns/1ps
module tmem_store #(
  parameter int SIDE  = 27,
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SIDE-1:0]  row_sel,
  input  logic [SIDE-1:0]  col_sel,
  input  logic             kill,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  localparam int CELLS = SIDE * SIDE;

  logic [WIDTH-1:0] cell_q [SIDE][SIDE];
  logic [CELLS-1:0] vld_q, vld_d;
  logic [WIDTH-1:0] rd_d, rd_q;

  // Storage cells: plain write-enabled registers, no reset
  always_ff @(posedge clk) begin
    for (int r = 0; r < SIDE; r++) begin
      for (int c = 0; c < SIDE; c++) begin
        if (wr_en && row_sel[r] && col_sel[c]) cell_q[r][c] <= wdata;
      end
    end
  end

  // Written-since-reset flags
  always_comb begin
    vld_d = vld_q;
    for (int r = 0; r < SIDE; r++) begin
      for (int c = 0; c < SIDE; c++) begin
        if (wr_en && row_sel[r] && col_sel[c]) vld_d[r*SIDE + c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Read path: AND-OR over the crossing of both selects
  always_comb begin
    rd_d = '0;
    for (int r = 0; r < SIDE; r++) begin
      for (int c = 0; c < SIDE; c++) begin
        if (row_sel[r] && col_sel[c] && vld_q[r*SIDE + c]) rd_d = rd_d | cell_q[r][c];
      end
    end
    if (kill) rd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

  logic rd_has_bad;
  always_comb begin
    rd_has_bad = 1'b0;
    for (int i = 0; i < WIDTH/2; i++) rd_has_bad = rd_has_bad | (&rd_q[2*i +: 2]);
  end

  // R1
  rd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_has_bad);

endmodule

// File: rtl/tmem_top.sv
`timescale 1ns/1ps
module tmem_top
  import tmem_pkg::*;
#(
  parameter int HALF_TRITS = 3,
  parameter int DATA_TRITS = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [4*HALF_TRITS-1:0]   addr,
  input  logic [2*DATA_TRITS-1:0]   wr_data,
  output logic [2*DATA_TRITS-1:0]   rd_data,
  output logic                      err
);

  localparam int SIDE   = pow3(HALF_TRITS);
  localparam int HALF_W = 2 * HALF_TRITS;
  localparam int DW     = 2 * DATA_TRITS;

  logic            rst_s_n;
  logic [SIDE-1:0] row_sel, col_sel;
  logic            row_bad, col_bad, data_bad, req_bad, wr_fire;
  logic            err_d, err_q;

  tmem_rst_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  tmem_tri_decoder #(.NTRITS(HALF_TRITS)) u_row_dec (
    .trits_i (addr[2*HALF_W-1:HALF_W]),
    .sel_o   (row_sel),
    .bad_o   (row_bad)
  );

  tmem_tri_decoder #(.NTRITS(HALF_TRITS)) u_col_dec (
    .trits_i (addr[HALF_W-1:0]),
    .sel_o   (col_sel),
    .bad_o   (col_bad)
  );

  always_comb begin
    data_bad = 1'b0;
    for (int i = 0; i < DATA_TRITS; i++) data_bad = data_bad | (wr_data[2*i +: 2] == TRIT_BAD);
  end

  assign req_bad = row_bad | col_bad | (wr_en & data_bad);
  assign wr_fire = wr_en & ~req_bad & rst_s_n;

  tmem_store #(.SIDE(SIDE), .WIDTH(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_fire),
    .row_sel (row_sel),
    .col_sel (col_sel),
    .kill    (req_bad),
    .wdata   (wr_data),
    .rdata   (rd_data)
  );

  always_comb begin
    err_d = req_bad;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign err = err_q;

  // R8
  row_dec_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones(row_sel) == (row_bad ? 0 : 1));

  // R8
  col_dec_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones(col_sel) == (col_bad ? 0 : 1));

  // R4
  wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(wr_fire) && (addr == $past(addr)) && !req_bad) |=> (rd_data == $past(wr_data, 2)));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    err |-> (rd_data == '0));

  // R5
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$past(rst_s_n) |-> (rd_data == '0 && !err));

endmodule

// File: tb/sim_tmem_top.sv
`timescale 1ns/1ps
module sim_tmem_top;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, err;
  logic [11:0] addr, wr_data, rd_data;

  always #2 clk = ~clk;

  tmem_top u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .err     (err)
  );

  typedef struct {
    logic [11:0] d;
    logic        e;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [11:0] ref_mem [729];

  // R1 encoding: -1 -> 10, 0 -> 00, +1 -> 01
  function automatic logic [1:0] enc(input int t);
    if (t < 0) return 2'b10;
    if (t > 0) return 2'b01;
    return 2'b00;
  endfunction

  function automatic int dec(input logic [1:0] c);
    if (c == 2'b10) return -1;
    if (c == 2'b01) return 1;
    return 0;
  endfunction

  function automatic logic [11:0] pack6(input int v);
    logic [11:0] w;
    int          x, d;
    x = v;
    for (int i = 0; i < 6; i++) begin
      d = x % 3;
      if (d > 1) d = d - 3;
      if (d < -1) d = d + 3;
      w[2*i +: 2] = enc(d);
      x = (x - d) / 3;
    end
    return w;
  endfunction

  function automatic logic has_bad(input logic [11:0] w);
    for (int i = 0; i < 6; i++) if (w[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  // R2: row = trits 5..3, column = trits 2..0, index = value + 13
  function automatic int idx_of(input logic [11:0] a);
    int rv, cv, wt;
    rv = 0; cv = 0; wt = 1;
    for (int i = 0; i < 3; i++) begin
      cv = cv + wt * dec(a[2*i +: 2]);
      rv = rv + wt * dec(a[2*i+6 +: 2]);
      wt = wt * 3;
    end
    return (rv + 13) * 27 + (cv + 13);
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: err,rd_data=%b,%h expected %b,%h", tag, act[12], act[11:0], exp[12], exp[11:0]);
    end
  endtask

  // Driver: apply one request and push its expected result
  task automatic op(input logic w, input logic [11:0] a, input logic [11:0] d, input string tag);
    exp_t e;
    int   k;
    @(negedge clk);
    wr_en   = w;
    addr    = a;
    wr_data = d;
    e.tag   = tag;
    if (has_bad(a) || (w && has_bad(d))) begin
      e.d = '0;
      e.e = 1'b1;
    end else begin
      k   = idx_of(a);
      e.d = ref_mem[k];
      e.e = 1'b0;
      if (w) ref_mem[k] = d;
    end
    sb.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    wr_en = 1'b0;
    while (sb.size() > 0) @(posedge clk);
    #2;
  endtask

  // Monitor: compare results one edge after each request
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check(e.tag, {err, rd_data}, {e.e, e.d});
    end
  end

  initial begin
    #800000;
    n_cmp++;
    n_bad++;
    $display("FAIL R4 watchdog: done=0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] a, d;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    addr    = '0;
    wr_data = '0;
    for (int i = 0; i < 729; i++) ref_mem[i] = '0;

    repeat (3) @(posedge clk);
    #1 check("R5 reset", {err, rd_data}, 13'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: untouched cells read zero
    op(1'b0, pack6(-364), '0, "R5");
    op(1'b0, pack6(0), '0, "R5");
    op(1'b0, pack6(364), '0, "R5");
    drain();

    // R3 / R1: corner addresses with mixed trit codes
    op(1'b1, pack6(-364), pack6(364), "R3");
    op(1'b1, pack6(364), pack6(-364), "R3");
    op(1'b1, pack6(0), pack6(100), "R3");
    op(1'b0, pack6(-364), '0, "R1");
    op(1'b0, pack6(364), '0, "R1");
    op(1'b0, pack6(0), '0, "R1");
    drain();

    // R4: read-before-write on the same edge
    op(1'b1, pack6(77), pack6(11), "R4");
    op(1'b1, pack6(77), pack6(-200), "R4");
    op(1'b0, pack6(77), '0, "R4");
    drain();

    // R2 / R8: every address gets a distinct word, then read all back
    for (int i = 0; i < 729; i++)
      op(1'b1, pack6((i/27 - 13) * 27 + (i%27 - 13)), pack6(((i * 7) % 729) - 364), "R2");
    for (int i = 0; i < 729; i++)
      op(1'b0, pack6((i/27 - 13) * 27 + (i%27 - 13)), '0, "R8");
    drain();

    // R6: illegal code in a row trit, then in a column trit
    a = pack6(5 * 27 + 3);
    a[9:8] = 2'b11;
    op(1'b1, a, pack6(7), "R6");
    op(1'b0, a, '0, "R6");
    a[9:8] = 2'b10; op(1'b0, a, '0, "R6");
    a[9:8] = 2'b00; op(1'b0, a, '0, "R6");
    a[9:8] = 2'b01; op(1'b0, a, '0, "R6");
    a = pack6(-40);
    a[1:0] = 2'b11;
    op(1'b1, a, pack6(3), "R6");
    a[1:0] = 2'b10; op(1'b0, a, '0, "R6");
    a[1:0] = 2'b00; op(1'b0, a, '0, "R6");
    a[1:0] = 2'b01; op(1'b0, a, '0, "R6");
    drain();

    // R7: illegal data code with and without the write strobe
    d = pack6(5);
    d[3:2] = 2'b11;
    op(1'b1, pack6(40), d, "R7");
    op(1'b0, pack6(40), '0, "R7");
    op(1'b0, pack6(40), d, "R7");
    drain();

    // R9: asynchronous clear between clock edges
    @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5 check("R9 async", {err, rd_data}, 13'd0);
    for (int i = 0; i < 729; i++) ref_mem[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    op(1'b0, pack6(-364), '0, "R5");
    op(1'b0, pack6(364), '0, "R5");
    op(1'b0, pack6(77), '0, "R5");
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule